// File: doc/BRIEF.md
# Occupancy Histogram Scaler Bank

This block records how long the count of triggers waiting for a second-level decision stays at each possible value. A free-running prescaler divides the tick clock down to a slow sampling strobe, 1 kHz by default with a 50 MHz clock. On each strobe, a decoder turns the current 5-bit count into a one-hot enable. Only the bin that matches the count advances its own 16-bit saturating scaler. There are seventeen bins, one for each count value from 0 to 16.

A count above 16 is not expected in normal running. When one is seen on a strobe, no bin advances and a sticky flag is raised instead. The bins and the flag can be cleared in two ways: a host-forced reset bit, or the timing-system reset strobe when its enable bit is set. The host picks a bin with a read index and sees that bin's value on the read port.

Top module: `occ_hist_bank`

## Requirements
- R1: There are NUM_BINS (17) scalers of SCL_W (16) bits each. A read index b in the range 0..16 shows the value of bin b on `rd_data_o` in the same cycle.
- R2: The sample strobe is high for one cycle out of every DIV_RATIO cycles. Its first high cycle is the DIV_RATIO-th rising edge after reset is released. The default of 50000 gives 1 kHz at 50 MHz.
- R3: On a strobe edge where `count_i` is in the range 0..16, the bin equal to `count_i` rises by one and every other bin keeps its value.
- R4: On clock edges without a strobe, no bin changes.
- R5: A bin that holds the all-ones value (0xFFFF by default) stays at that value when it is sampled again. It does not wrap.
- R6: On a strobe edge where `count_i` is greater than 16, no bin advances and `overflow_o` goes high. It stays high until a histogram clear.
- R7: When `ts_reset_i` and `ts_reset_en_i` are both high at a rising edge, every bin and `overflow_o` are cleared at that edge. When `ts_reset_en_i` is low, `ts_reset_i` has no effect.
- R8: When `force_reset_i` is high at a rising edge, every bin and `overflow_o` are cleared. A clear takes priority over an increment at the same edge.
- R9: A read index above 16 returns zero.
- R10: While `rst_ni` is low, all bins, `overflow_o` and the prescaler are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 5 | Outstanding-decision count being sampled |
| ts_reset_i | input | 1 | Timing-system reset strobe |
| ts_reset_en_i | input | 1 | Lets the timing strobe clear the histogram |
| force_reset_i | input | 1 | Host-forced histogram clear |
| rd_idx_i | input | 5 | Bin selected for readout |
| rd_data_o | output | 16 | Value of the selected bin |
| overflow_o | output | 1 | Sticky flag: a count above 16 was sampled |

## Verification
The bench checks the exact edge of the first strobe. A prescaler that is off by one would move every increment one cycle away from where the bench expects it. Both clear paths are tested while a strobe falls inside the clear window. A design that let the increment win would leave a bin at one where zero is expected.

The timing strobe is also pulsed with its enable low. A design that ignored the enable would wipe a histogram that should survive. The bench drives bins past the all-ones value, using a narrower bin width so the run stays short, and catches any design that wraps to zero. It samples counts above 16 and catches any design that lets such a count advance a bin or fails to hold the overflow flag.

// File: rtl/hist_pkg.sv
package hist_pkg;
  // counter width for a modulus, never below 1
  function automatic int unsigned mod_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/hist_prescaler.sv
module hist_prescaler #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic stb_o
);
  localparam int unsigned CW = hist_pkg::mod_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign stb_o = (cnt_q == LAST);

  // R2
  single_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
endmodule

// File: rtl/hist_scaler.sv
module hist_scaler #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   q_q <= '0;
    else if (clr_i)                q_q <= '0;
    else if (inc_i && q_q != MAX)  q_q <= q_q + 1'b1;
  end

  assign q_o = q_q;

  // R5
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q == MAX && !clr_i) |=> q_q == MAX);
  // R8
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> q_q == '0);
  // R4
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(q_q));
endmodule

// File: rtl/hist_readmux.sv
module hist_readmux #(
  parameter int unsigned W     = 16,
  parameter int unsigned BINS  = 17,
  parameter int unsigned IDX_W = 5
) (
  input  logic [BINS-1:0][W-1:0] bins_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [W-1:0]           data_o
);
  always_comb begin
    data_o = '0;
    for (int b = 0; b < BINS; b++)
      if (idx_i == IDX_W'(b)) data_o = bins_i[b];
  end
endmodule

// File: rtl/occ_hist_bank.sv
module occ_hist_bank #(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned NUM_BINS  = 17,
  parameter int unsigned SCL_W     = 16,
  parameter int unsigned DIV_RATIO = 50000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             ts_reset_i,
  input  logic             ts_reset_en_i,
  input  logic             force_reset_i,
  input  logic [CNT_W-1:0] rd_idx_i,
  output logic [SCL_W-1:0] rd_data_o,
  output logic             overflow_o
);
  localparam logic [CNT_W-1:0] TOP_VAL = CNT_W'(NUM_BINS - 1);

  logic                         stb;
  logic                         clr;
  logic                         ovr_hit;
  logic [NUM_BINS-1:0]          bin_en;
  logic [NUM_BINS-1:0][SCL_W-1:0] bin_q;
  logic                         ovf_q;

  assign clr = force_reset_i | (ts_reset_i & ts_reset_en_i);

  hist_prescaler #(.DIV(DIV_RATIO)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_o (stb)
  );

  // one-hot decode of the sampled count
  for (genvar b = 0; b < NUM_BINS; b++) begin : g_dec
    assign bin_en[b] = stb && (count_i == CNT_W'(b));
  end
  assign ovr_hit = stb && (count_i > TOP_VAL);

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    hist_scaler #(.W(SCL_W)) u_scl (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr),
      .inc_i (bin_en[b]),
      .q_o   (bin_q[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovf_q <= 1'b0;
    else if (clr)     ovf_q <= 1'b0;
    else if (ovr_hit) ovf_q <= 1'b1;
  end
  assign overflow_o = ovf_q;

  hist_readmux #(.W(SCL_W), .BINS(NUM_BINS), .IDX_W(CNT_W)) u_rd (
    .bins_i(bin_q),
    .idx_i (rd_idx_i),
    .data_o(rd_data_o)
  );

  // R3
  dec_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bin_en) && !(ovr_hit && bin_en != '0));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !clr) |=> overflow_o);
  // R7
  clr_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !overflow_o);
  // R9
  rd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i > TOP_VAL) |-> rd_data_o == '0);
endmodule

// File: tb/occ_hist_bank_tb.sv
module occ_hist_bank_tb_top;
  localparam int unsigned DIV  = 4;
  localparam int unsigned SW   = 8;
  localparam int unsigned NB   = 17;
  localparam logic [SW-1:0] MAXV = '1;

  logic clk = 1'b0;
  logic rst_n;
  logic [4:0] count, rd_idx;
  logic ts, ts_en, force_r;
  logic [SW-1:0] rd_data;
  logic ovf;

  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;

  occ_hist_bank #(.CNT_W(5), .NUM_BINS(NB), .SCL_W(SW), .DIV_RATIO(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .count_i(count), .ts_reset_i(ts),
    .ts_reset_en_i(ts_en), .force_reset_i(force_r), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .overflow_o(ovf)
  );

  // reference model from the requirements
  int unsigned m_pre;
  logic [SW-1:0] m_bins [NB];
  logic m_ovf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= 0;
      m_ovf <= 1'b0;
      for (int i = 0; i < NB; i++) m_bins[i] <= '0;
    end else begin
      m_pre <= (m_pre == DIV - 1) ? 0 : m_pre + 1;
      if (force_r || (ts && ts_en)) begin
        m_ovf <= 1'b0;
        for (int i = 0; i < NB; i++) m_bins[i] <= '0;
      end else if (m_pre == DIV - 1) begin
        if (count < NB) begin
          if (m_bins[count] != MAXV) m_bins[count] <= m_bins[count] + 1'b1;
        end else m_ovf <= 1'b1;
      end
    end
  end

  function automatic logic [SW-1:0] exp_bin(int idx);
    return (idx < NB) ? m_bins[idx] : '0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_bin(int idx, string req);
    @(negedge clk);
    rd_idx = 5'(idx);
    #1;
    chk(req, 32'(rd_data), 32'(exp_bin(idx)));
  endtask

  task automatic cmp_ovf(string req);
    chk(req, 32'(ovf), 32'(m_ovf));
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 32; i++) cmp_bin(i, req);
    cmp_ovf(req);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    count = 5'd3; ts = 0; ts_en = 0; force_r = 0; rd_idx = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    rd_idx = 5'd3;
    #1;
    chk("R10 bin after reset", 32'(rd_data), 32'd0);
    chk("R10 ovf after reset", 32'(ovf), 32'd0);
    rst_n = 1;
    // R2: first strobe lands on edge DIV, then every DIV edges
    for (int c = 0; c < 3 * DIV; c++) cmp_bin(3, "R2 strobe timing");
    chk("R2 three samples", 32'(rd_data), 32'd3);

    // R3 R4: random counts, hold times and read indexes
    for (int it = 0; it < 60; it++) begin
      @(negedge clk);
      count = (($urandom % 8) == 0) ? 5'(17 + $urandom % 15) : 5'($urandom % 17);
      for (int h = 0; h < 1 + int'($urandom % 6); h++)
        cmp_bin((count < NB) ? int'(count) : int'($urandom % 17), "R3 R4 random");
      cmp_ovf("R6 random");
    end
    sweep("R1 R9 full read");

    // R7: timing strobe without enable is ignored
    @(negedge clk); count = 5'd9; ts = 1; ts_en = 0;
    @(negedge clk); ts = 0;
    sweep("R7 ts ignored");
    // R7: enabled timing strobe clears
    @(negedge clk); ts = 1; ts_en = 1;
    @(negedge clk); ts = 0;
    #1; rd_idx = 5'd9; #1;
    chk("R7 ts clear", 32'(rd_data), 32'(exp_bin(9)));
    sweep("R7 after clear");

    // R8: forced clear held across strobes beats increment
    @(negedge clk); count = 5'd7;
    for (int c = 0; c < 2 * DIV; c++) cmp_bin(7, "R8 pre");
    @(negedge clk); force_r = 1;
    for (int c = 0; c < 3 * DIV; c++) begin
      cmp_bin(7, "R8 held");
      chk("R8 held zero", 32'(rd_data), 32'd0);
    end
    @(negedge clk); force_r = 0;
    sweep("R8 released");

    // R5: saturation
    @(negedge clk); count = 5'd5;
    repeat ((int'(MAXV) + 6) * DIV) @(negedge clk);
    cmp_bin(5, "R5 saturate");
    chk("R5 all ones", 32'(rd_data), 32'(MAXV));

    // R6: out-of-range count raises sticky flag, no bin moves
    @(negedge clk); count = 5'd25;
    repeat (2 * DIV) @(negedge clk);
    #1;
    chk("R6 ovf set", 32'(ovf), 32'd1);
    @(negedge clk); count = 5'd2;
    repeat (2 * DIV) @(negedge clk);
    #1;
    chk("R6 ovf sticky", 32'(ovf), 32'd1);
    sweep("R6 bins");
    cmp_bin(17, "R9 idx17");
    chk("R9 idx17 zero", 32'(rd_data), 32'd0);
    cmp_bin(31, "R9 idx31");
    chk("R9 idx31 zero", 32'(rd_data), 32'd0);
    finish_run();
  end
endmodule